// File: doc/BRIEF.md
# Fractional Constant Shift-Add Multiplier (seven eighths)

The block scales a stream of signed two's-complement samples by the constant 7/8. It uses no hardware multiplier. The factor 7 is built as eight minus one: the sample shifted left by three bits, less the sample itself. The division by eight is an arithmetic right shift by three bits. Each accepted sample produces one registered result, and the output valid flag follows the input valid flag by exactly one clock.

A parameter fixes the order of the two steps. In the default order, the block forms the full product 7·x in a widened intermediate and then shifts it down, so every input bit takes part in the product. In the alternate order, the block shifts the sample down first and then multiplies by seven. The three low bits are discarded before the product is formed, which gives a visibly larger error. Both orders truncate toward negative infinity. Instantiating both orders side by side lets the quantization error of each be compared directly.

Top module: `frac78_mul`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0.
- R2: `out_valid` equals the value `in_valid` had one clock earlier, with a latency of exactly one cycle.
- R3: With ORDER = ORD_MUL_FIRST, one cycle after a valid input x, `out_data` equals floor(7·x/8).
- R4: With ORDER = ORD_SCALE_FIRST, one cycle after a valid input x, `out_data` equals 7·floor(x/8).
- R5: The intermediate seven-times product is DATA_W+3 bits wide and never overflows: it is zero exactly when x is zero, and otherwise it has the sign of x.
- R6: In a cycle with `in_valid` low, the next `out_data` keeps its previous value, whatever is on `in_data`.
- R7: Both orders truncate toward negative infinity. For x = -1 the default order gives -1 and the alternate order gives -7. For the most negative input -2^(DATA_W-1), the default order gives -7·2^(DATA_W-4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears the output valid flag |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | DATA_W | Signed scaled result |

## Verification
A wrong shift amount, a missing sign extension or a dropped subtraction shows up at the ports one cycle after a valid sample. The symptom is an `out_data` value that differs from the floor-based reference. The difference is largest near the extremes of the input range and for negative odd inputs. A fault in the valid register appears in the cycle that follows any change of `in_valid`. A fault in the hold path appears as a changed `out_data` after an idle cycle. Running both orders on the same random stream shows each order's own rounding pattern. An implementation that confused the orders would fail on most inputs whose low three bits are nonzero.

// File: rtl/frac78_pkg.sv
package frac78_pkg;
  // Order of the two arithmetic steps.
  typedef enum logic {
    ORD_SCALE_FIRST = 1'b0,
    ORD_MUL_FIRST   = 1'b1
  } order_e;

  // log2 of the divisor; the multiplier is (2**FRAC_SHIFT) - 1.
  localparam int FRAC_SHIFT = 3;
endpackage

// File: rtl/frac78_times7.sv
// Seven-times product by shift and subtract: (a << 3) - a, widened to avoid overflow.
module frac78_times7 #(
  parameter int IN_W = 12
) (
  input  logic signed [IN_W-1:0]                          a,
  output logic signed [IN_W+frac78_pkg::FRAC_SHIFT-1:0]   p
);
  localparam int P_W = IN_W + frac78_pkg::FRAC_SHIFT;

  logic signed [P_W-1:0] a_ext;
  logic signed [P_W-1:0] a_up;

  always_comb begin
    a_ext = P_W'(a);
    a_up  = a_ext <<< frac78_pkg::FRAC_SHIFT;
    p     = a_up - a_ext;
  end
endmodule

// File: rtl/frac78_shr.sv
// Divide by 2**FRAC_SHIFT as an arithmetic shift, which truncates toward negative infinity.
module frac78_shr #(
  parameter int W = 12
) (
  input  logic signed [W-1:0] a,
  output logic signed [W-1:0] q
);
  always_comb q = a >>> frac78_pkg::FRAC_SHIFT;
endmodule

// File: rtl/frac78_mul.sv
module frac78_mul
  import frac78_pkg::*;
#(
  parameter int     DATA_W = 12,
  parameter order_e ORDER  = ORD_MUL_FIRST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int P_W = DATA_W + FRAC_SHIFT;

  // Reference arithmetic, written with a true multiply for the assertions.
  function automatic logic signed [DATA_W-1:0] ref_scale(input logic signed [DATA_W-1:0] x);
    logic signed [P_W-1:0] t;
    if (ORDER == ORD_MUL_FIRST) begin
      t = P_W'(x) * 7;
      t = t >>> FRAC_SHIFT;
    end else begin
      t = P_W'(x >>> FRAC_SHIFT) * 7;
    end
    return t[DATA_W-1:0];
  endfunction

  logic signed [DATA_W-1:0] x_s;
  logic signed [DATA_W-1:0] mul_in;   // operand fed to the x7 stage
  logic signed [P_W-1:0]    prod;     // intermediate seven-times product
  logic signed [DATA_W-1:0] result;   // combinational result before register

  assign x_s = $signed(in_data);

  generate
    if (ORDER == ORD_MUL_FIRST) begin : g_mul_first
      logic signed [P_W-1:0] prod_down;
      assign mul_in = x_s;
      frac78_times7 #(.IN_W(DATA_W)) u_x7 (.a(mul_in), .p(prod));
      frac78_shr    #(.W(P_W))       u_sh (.a(prod),   .q(prod_down));
      assign result = prod_down[DATA_W-1:0];
    end else begin : g_scale_first
      logic signed [DATA_W-1:0] x_down;
      frac78_shr    #(.W(DATA_W))    u_sh (.a(x_s),    .q(x_down));
      assign mul_in = x_down;
      frac78_times7 #(.IN_W(DATA_W)) u_x7 (.a(mul_in), .p(prod));
      assign result = prod[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) out_data <= result;
  end

  AST_VALID_RISE:  assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);          // R2
  AST_VALID_FALL:  assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);        // R2
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> !out_valid);                               // R1
  AST_RESULT:      assert property (@(posedge clk) disable iff (!rst_n)
                     in_valid |=> (out_data == $past(ref_scale(x_s))));                                  // R3
  AST_HOLD:        assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_data)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
                     (mul_in == '0) ? (prod == '0) : (prod[P_W-1] == mul_in[DATA_W-1]));                // R5
endmodule

// File: tb/frac78_mul_bench.sv
module frac78_mul_bench;
  import frac78_pkg::*;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic mf_valid, sf_valid;
  logic [W-1:0] mf_data, sf_data;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  frac78_mul #(.DATA_W(W), .ORDER(ORD_MUL_FIRST)) u_frac78_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(mf_valid), .out_data(mf_data));

  frac78_mul #(.DATA_W(W), .ORDER(ORD_SCALE_FIRST)) u_frac78_mul_alt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(sf_valid), .out_data(sf_data));

  // floor(7x/8) by integer division with correction for negatives
  function automatic int exp_mf(input int x);
    int n, q;
    n = 7 * x;
    q = n / 8;
    if ((n % 8 != 0) && (n < 0)) q = q - 1;
    return q;
  endfunction

  function automatic int exp_sf(input int x);
    int q;
    q = x / 8;
    if ((x % 8 != 0) && (x < 0)) q = q - 1;
    return 7 * q;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input int x, input string req_mf, input string req_sf);
    in_valid = 1'b1;
    in_data  = W'(x);
    @(negedge clk);
    check("R2", int'(mf_valid), 1);
    check(req_mf, int'($signed(mf_data)), exp_mf(x));
    check(req_sf, int'($signed(sf_data)), exp_sf(x));
  endtask

  initial begin
    int seed_dummy;
    int lo, hi;
    logic [W-1:0] held_mf, held_sf;
    seed_dummy = $urandom(32'h1234);
    lo = -(1 << (W-1));
    hi = (1 << (W-1)) - 1;
    repeat (3) @(negedge clk);
    check("R1", int'(mf_valid), 0);
    check("R1", int'(sf_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(mf_valid), 0);

    apply(0, "R3", "R4");
    apply(1, "R3", "R4");
    apply(-1, "R7", "R7");
    apply(7, "R3", "R4");
    apply(8, "R3", "R4");
    apply(-8, "R7", "R7");
    apply(-9, "R7", "R7");
    apply(9, "R3", "R4");
    apply(hi, "R5", "R4");
    apply(lo, "R7", "R7");
    check("R7", exp_mf(lo), -7 * (1 << (W-4)));

    // idle cycle: outputs must hold
    held_mf = mf_data;
    held_sf = sf_data;
    in_valid = 1'b0;
    in_data  = 12'h5A5;
    @(negedge clk);
    check("R2", int'(mf_valid), 0);
    check("R6", int'(mf_data), int'(held_mf));
    check("R6", int'(sf_data), int'(held_sf));

    for (int i = 0; i < 400; i++) begin
      int x;
      x = int'($signed(W'($urandom)));
      if ($urandom % 4 == 0) begin
        held_mf = mf_data;
        held_sf = sf_data;
        in_valid = 1'b0;
        in_data  = W'(x);
        @(negedge clk);
        check("R2", int'(sf_valid), 0);
        check("R6", int'(mf_data), int'(held_mf));
        check("R6", int'(sf_data), int'(held_sf));
      end else begin
        apply(x, "R3", "R4");
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule